// File: doc/BRIEF.md
# Pipelined Predicate-Path Predictor

This block predicts the outcomes of a fixed number of predicates inside one instruction block, producing one predicate per clock through a three-stage pipeline. Each prediction hashes the block address with a long global history into several tables of signed saturating counters. The counters chosen by the hash are summed. The sign of the sum gives the predicted value, and its magnitude, compared with a threshold, gives a confidence bit. Once every predicate of the block has been produced, the predicted path and its confidence bits appear together with a one-cycle valid pulse. The history snapshot the block was hashed with is presented alongside them.

Each table read returns a pair of neighbouring counters. Of the pair, the counter is picked by the prediction for the previous predicate, which is still in the summing stage at that moment. The next predicate is therefore steered by the one before it without stalling. The history is advanced speculatively with the predicted path. A later training request carries the address, the history snapshot, the predicted path and the resolved path. It adjusts the counters one predicate per cycle and, if the path was wrong, rebuilds the history.

Top module: `ghpp_top`

## Requirements
- R1: After reset every counter is zero, the history is zero, `predValid` is low and `predHist` is zero. The first block predicted after reset therefore yields path all ones with confidence all zeros.
- R2: A request is accepted on a rising edge where `predReq` is high and no block is in flight. `predValid` is then high for exactly one cycle, the cycle after the (NUM_PRED+1)-th rising edge following the accepting edge. Requests made while a block is in flight are ignored.
- R3: For predicate k and table t, the counter index is {base, prev}, with `prev` as its least significant bit. Here base = fold_t XOR addr[IDX_W-2:0] XOR k. fold_t XORs history bit i into base bit (i mod (IDX_W-1)) for every i below HIST_MIN·2^t.
- R4: The counters are 4-bit two's complement values from -8 to 7. The predicted bit is 1 when their sum is at least zero. The confidence bit is 1 when the absolute value of the sum exceeds THRESH (default 3).
- R5: `prev` is 0 for predicate 0. For every later predicate it is the predicted bit of the preceding predicate of the same block.
- R6: When `predValid` rises, the history becomes {old history shifted up by NUM_PRED, predicted path}, with path bit k at history bit k. `predHist` holds the history value taken at the accepting edge.
- R7: Training walks predicates 0 to NUM_PRED-1, one per cycle. It uses the R3 indexes with `prev` taken from the supplied predicted path. A predicate trains when its predicted bit differs from its resolved bit or when the absolute value of its current sum is at most THRESH. Each indexed counter then moves one step toward the resolved bit and holds at 7 or -8.
- R8: When an accepted training request has predicted path different from resolved path, the history becomes {supplied snapshot shifted up by NUM_PRED, resolved path}. This takes priority over a speculative advance on the same edge. Otherwise the history is left alone.
- R9: A training request is accepted only when no training is in progress, and it takes NUM_PRED cycles. `updValid` during those cycles is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| predReq | input | 1 | Predict request |
| predAddr | input | ADDR_W | Block address for the request |
| predValid | output | 1 | One-cycle pulse: path and confidence ready |
| predPath | output | NUM_PRED | Predicted predicate bits, bit k for predicate k |
| predConf | output | NUM_PRED | Confidence bits, bit k for predicate k |
| predHist | output | HIST_W | History snapshot used for this block |
| updValid | input | 1 | Training request |
| updAddr | input | ADDR_W | Block address being trained |
| updHist | input | HIST_W | History snapshot of that block |
| updPredPath | input | NUM_PRED | Path that was predicted |
| updActualPath | input | NUM_PRED | Path that was resolved |

## Verification
The hardest case to reach from the ports is a predicate whose counters depend on the bit just predicted for its neighbour. Exercising it needs trained, non-zero counters sitting behind both `prev` values, under a history that recurs. The stimulus walks a vector table of addresses and resolved paths, and each block is trained immediately after it is predicted. Repeated all-zero and alternating paths make the short-history tables revisit the same entries and split on the previous bit. A reference model computes every expected path. A separate run of twenty trainings on one entry drives a counter into saturation, so a wrap-around shows as a sign flip in predicate 0.

// File: rtl/ghpp_pkg.sv
package ghpp_pkg;
  localparam int K_W = 4;

  typedef struct packed {
    logic           predAccept;
    logic           issue;
    logic [K_W-1:0] issueK;
    logic           done;
    logic           updAccept;
    logic           updStep;
    logic [K_W-1:0] updK;
  } ghpp_strobe_t;
endpackage

// File: rtl/ghpp_ctrl.sv
module ghpp_ctrl
  import ghpp_pkg::*;
#(
  parameter int NUM_PRED = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         predReq,
  input  logic         updValid,
  output ghpp_strobe_t stb
);
  localparam int CYC_W = $clog2(NUM_PRED + 2) + 1;

  logic             busy;
  logic [CYC_W-1:0] cyc;
  logic             updBusy;
  logic [K_W-1:0]   updK;

  always_comb begin
    stb.predAccept = !busy && predReq;
    stb.issue      = stb.predAccept || (busy && cyc < CYC_W'(NUM_PRED));
    stb.issueK     = stb.predAccept ? '0 : K_W'(cyc);
    stb.done       = busy && (cyc == CYC_W'(NUM_PRED + 1));
    stb.updAccept  = !updBusy && updValid;
    stb.updStep    = updBusy;
    stb.updK       = updK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cyc  <= '0;
    end else if (stb.predAccept) begin
      busy <= 1'b1;
      cyc  <= CYC_W'(1);
    end else if (busy) begin
      if (stb.done) begin
        busy <= 1'b0;
        cyc  <= '0;
      end else begin
        cyc <= cyc + CYC_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updBusy <= 1'b0;
      updK    <= '0;
    end else if (stb.updAccept) begin
      updBusy <= 1'b1;
      updK    <= '0;
    end else if (updBusy) begin
      if (updK == K_W'(NUM_PRED - 1)) updBusy <= 1'b0;
      else updK <= updK + K_W'(1);
    end
  end
endmodule

// File: rtl/ghpp_datapath.sv
module ghpp_datapath
  import ghpp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int HIST_W     = 200,
  parameter int NUM_TABLES = 5,
  parameter int IDX_W      = 7,
  parameter int CTR_W      = 4,
  parameter int NUM_PRED   = 4,
  parameter int HIST_MIN   = 5,
  parameter int THRESH     = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  ghpp_strobe_t        stb,
  input  logic [ADDR_W-1:0]   predAddr,
  input  logic [ADDR_W-1:0]   updAddr,
  input  logic [HIST_W-1:0]   updHist,
  input  logic [NUM_PRED-1:0] updPredPath,
  input  logic [NUM_PRED-1:0] updActualPath,
  output logic                predValid,
  output logic [NUM_PRED-1:0] predPath,
  output logic [NUM_PRED-1:0] predConf,
  output logic [HIST_W-1:0]   predHist
);
  localparam int BASE_W  = IDX_W - 1;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int SUM_W   = CTR_W + $clog2(NUM_TABLES) + 1;
  localparam int KI_W    = $clog2(NUM_PRED);
  localparam logic [CTR_W-1:0] MAXP = {1'b0, {(CTR_W-1){1'b1}}};
  localparam logic [CTR_W-1:0] MINP = {1'b1, {(CTR_W-1){1'b0}}};

  function automatic logic [BASE_W-1:0] foldHist(input logic [HIST_W-1:0] h, input int len);
    logic [BASE_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < HIST_W; i++)
      if (i < len) acc[i % BASE_W] = acc[i % BASE_W] ^ h[i];
    return acc;
  endfunction

  function automatic logic [BASE_W-1:0] baseOf(input int t, input logic [ADDR_W-1:0] a,
                                                input logic [HIST_W-1:0] h, input logic [K_W-1:0] k);
    return foldHist(h, HIST_MIN << t) ^ a[BASE_W-1:0] ^ BASE_W'(k);
  endfunction

  function automatic logic signed [SUM_W-1:0] sext(input logic [CTR_W-1:0] c);
    return {{(SUM_W-CTR_W){c[CTR_W-1]}}, c};
  endfunction

  logic [HIST_W-1:0]   ghr, histReg;
  logic [ADDR_W-1:0]   addrReg, curAddr;
  logic [HIST_W-1:0]   curHist;
  logic [BASE_W-1:0]   s1Base [NUM_TABLES];
  logic                s1V, s2V;
  logic [K_W-1:0]      s1K, s2K;
  logic [CTR_W-1:0]    selCtr [NUM_TABLES];
  logic [CTR_W-1:0]    s2Ctr  [NUM_TABLES];
  logic signed [SUM_W-1:0] s3Sum;
  logic [SUM_W-1:0]    s3Mag;
  logic                s3Pred, s3Conf, prevBit;
  logic [NUM_PRED-1:0] pathReg, confReg, pathNext;
  logic                validReg;

  logic [ADDR_W-1:0]   uAddr;
  logic [HIST_W-1:0]   uHist;
  logic [NUM_PRED-1:0] uPred, uAct;
  logic [CTR_W-1:0]    uCur [NUM_TABLES];
  logic signed [SUM_W-1:0] uSum;
  logic [SUM_W-1:0]    uMag;
  logic                uPrevBit, uTrain, uDir;

  // Stage 1 operand mux: fresh request or held block
  assign curAddr = stb.predAccept ? predAddr : addrReg;
  assign curHist = stb.predAccept ? ghr : histReg;

  // Stage 3: summation of the selected counters
  always_comb begin
    s3Sum = '0;
    for (int t = 0; t < NUM_TABLES; t++) s3Sum = s3Sum + sext(s2Ctr[t]);
    s3Pred = (s3Sum >= 0);
    s3Mag  = s3Sum[SUM_W-1] ? SUM_W'(-s3Sum) : SUM_W'(s3Sum);
    s3Conf = (s3Mag > SUM_W'(THRESH));
    prevBit = (s1K == '0) ? 1'b0 : s3Pred;
    pathNext = pathReg;
    if (s2V) pathNext[KI_W'(s2K)] = s3Pred;
  end

  // Training step for predicate updK
  always_comb begin
    uPrevBit = (stb.updK == '0) ? 1'b0 : uPred[KI_W'(stb.updK - K_W'(1))];
    uSum = '0;
    for (int t = 0; t < NUM_TABLES; t++) uSum = uSum + sext(uCur[t]);
    uMag   = uSum[SUM_W-1] ? SUM_W'(-uSum) : SUM_W'(uSum);
    uDir   = uAct[KI_W'(stb.updK)];
    uTrain = (uPred[KI_W'(stb.updK)] != uDir) || (uMag <= SUM_W'(THRESH));
  end

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
    logic [CTR_W-1:0] mem [ENTRIES];
    logic [IDX_W-1:0] uIdx;
    assign uIdx      = {baseOf(t, uAddr, uHist, stb.updK), uPrevBit};
    assign uCur[t]   = mem[uIdx];
    assign selCtr[t] = prevBit ? mem[{s1Base[t], 1'b1}] : mem[{s1Base[t], 1'b0}];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
      end else if (stb.updStep && uTrain) begin
        if (uDir && uCur[t] != MAXP) mem[uIdx] <= uCur[t] + CTR_W'(1);
        else if (!uDir && uCur[t] != MINP) mem[uIdx] <= uCur[t] - CTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1V <= 1'b0; s1K <= '0; s2V <= 1'b0; s2K <= '0;
      for (int t = 0; t < NUM_TABLES; t++) begin
        s1Base[t] <= '0;
        s2Ctr[t]  <= '0;
      end
      addrReg <= '0; histReg <= '0; ghr <= '0;
      pathReg <= '0; confReg <= '0; validReg <= 1'b0;
      uAddr <= '0; uHist <= '0; uPred <= '0; uAct <= '0;
    end else begin
      s1V <= stb.issue;
      if (stb.issue) begin
        s1K <= stb.issueK;
        for (int t = 0; t < NUM_TABLES; t++) s1Base[t] <= baseOf(t, curAddr, curHist, stb.issueK);
      end
      if (stb.predAccept) begin
        addrReg <= predAddr;
        histReg <= ghr;
      end
      s2V <= s1V;
      s2K <= s1K;
      for (int t = 0; t < NUM_TABLES; t++) s2Ctr[t] <= selCtr[t];
      if (s2V) begin
        pathReg <= pathNext;
        confReg[KI_W'(s2K)] <= s3Conf;
      end
      validReg <= stb.done;
      if (stb.updAccept && (updPredPath != updActualPath))
        ghr <= {updHist[HIST_W-NUM_PRED-1:0], updActualPath};
      else if (stb.done)
        ghr <= {ghr[HIST_W-NUM_PRED-1:0], pathNext};
      if (stb.updAccept) begin
        uAddr <= updAddr; uHist <= updHist;
        uPred <= updPredPath; uAct <= updActualPath;
      end
    end
  end

  assign predValid = validReg;
  assign predPath  = pathReg;
  assign predConf  = confReg;
  assign predHist  = histReg;
endmodule

// File: rtl/ghpp_top.sv
module ghpp_top
  import ghpp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int HIST_W     = 200,
  parameter int NUM_TABLES = 5,
  parameter int IDX_W      = 7,
  parameter int CTR_W      = 4,
  parameter int NUM_PRED   = 4,
  parameter int HIST_MIN   = 5,
  parameter int THRESH     = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                predReq,
  input  logic [ADDR_W-1:0]   predAddr,
  output logic                predValid,
  output logic [NUM_PRED-1:0] predPath,
  output logic [NUM_PRED-1:0] predConf,
  output logic [HIST_W-1:0]   predHist,
  input  logic                updValid,
  input  logic [ADDR_W-1:0]   updAddr,
  input  logic [HIST_W-1:0]   updHist,
  input  logic [NUM_PRED-1:0] updPredPath,
  input  logic [NUM_PRED-1:0] updActualPath
);
  ghpp_strobe_t stb;

  ghpp_ctrl #(.NUM_PRED(NUM_PRED)) u_ctrl (
    .clk(clk), .rstN(rstN), .predReq(predReq), .updValid(updValid), .stb(stb)
  );

  ghpp_datapath #(
    .ADDR_W(ADDR_W), .HIST_W(HIST_W), .NUM_TABLES(NUM_TABLES), .IDX_W(IDX_W),
    .CTR_W(CTR_W), .NUM_PRED(NUM_PRED), .HIST_MIN(HIST_MIN), .THRESH(THRESH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .predAddr(predAddr),
    .updAddr(updAddr), .updHist(updHist), .updPredPath(updPredPath),
    .updActualPath(updActualPath), .predValid(predValid), .predPath(predPath),
    .predConf(predConf), .predHist(predHist)
  );
endmodule

// File: rtl/ghpp_checker.sv
module ghpp_checker #(
  parameter int NUM_PRED = 4,
  parameter int HIST_W   = 200
) (
  input logic              clk,
  input logic              rstN,
  input logic              predReq,
  input logic              predValid,
  input logic [HIST_W-1:0] predHist
);
  localparam int CW = $clog2(NUM_PRED + 2) + 1;
  logic [CW-1:0] pend;

  // Independent tracker of the in-flight window seen from the ports
  always_ff @(posedge clk) begin
    if (!rstN) pend <= '0;
    else if (pend == '0 && predReq) pend <= CW'(1);
    else if (pend == CW'(NUM_PRED + 1)) pend <= '0;
    else if (pend != '0) pend <= pend + CW'(1);
  end

  assert_reset_idle_R1: assert property (@(posedge clk) $rose(rstN) |-> !predValid);

  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    predValid |=> !predValid);

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pend == CW'(NUM_PRED + 1)) |=> predValid);

  assert_no_stray_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    predValid |-> ($past(pend) == CW'(NUM_PRED + 1)));

  assert_hist_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pend >= CW'(2)) |-> $stable(predHist));
endmodule

bind ghpp_top ghpp_checker #(.NUM_PRED(NUM_PRED), .HIST_W(HIST_W)) u_chk (
  .clk(clk), .rstN(rstN), .predReq(predReq), .predValid(predValid), .predHist(predHist)
);

// File: tb/ghpp_top_test.sv
module ghpp_top_test;
  localparam int NP = 4;
  localparam int NT = 5;
  localparam int HW = 200;
  localparam int BW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic predReq = 1'b0;
  logic [31:0] predAddr = '0;
  logic predValid;
  logic [NP-1:0] predPath, predConf;
  logic [HW-1:0] predHist;
  logic updValid = 1'b0;
  logic [31:0] updAddr = '0;
  logic [HW-1:0] updHist = '0;
  logic [NP-1:0] updPredPath = '0, updActualPath = '0;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  ghpp_top uut (
    .clk(clk), .rstN(rstN), .predReq(predReq), .predAddr(predAddr),
    .predValid(predValid), .predPath(predPath), .predConf(predConf), .predHist(predHist),
    .updValid(updValid), .updAddr(updAddr), .updHist(updHist),
    .updPredPath(updPredPath), .updActualPath(updActualPath)
  );

  // Reference model built from R3, R4, R5, R6, R7, R8
  int mTbl [NT][128];
  logic [HW-1:0] mGhr;
  logic [NP-1:0] lastPath, lastConf;
  logic [HW-1:0] lastHist;

  function automatic int mIdx(int t, logic [31:0] a, logic [HW-1:0] h, int k, logic prev);
    logic [BW-1:0] f;
    f = '0;
    for (int i = 0; i < (5 << t); i++) f[i % BW] = f[i % BW] ^ h[i];
    f = f ^ a[BW-1:0] ^ BW'(k);
    return int'({f, prev});
  endfunction

  task automatic mPredict(input logic [31:0] a, output logic [NP-1:0] p,
                          output logic [NP-1:0] c, output logic [HW-1:0] h);
    h = mGhr;
    p = '0; c = '0;
    for (int k = 0; k < NP; k++) begin
      int s;
      logic pv;
      pv = (k == 0) ? 1'b0 : p[k-1];
      s = 0;
      for (int t = 0; t < NT; t++) s += mTbl[t][mIdx(t, a, h, k, pv)];
      p[k] = (s >= 0);
      c[k] = ((s < 0 ? -s : s) > 3);
    end
    mGhr = {mGhr[HW-NP-1:0], p};
  endtask

  task automatic mUpdate(input logic [31:0] a, input logic [HW-1:0] h,
                         input logic [NP-1:0] pp, input logic [NP-1:0] ap);
    if (pp != ap) mGhr = {h[HW-NP-1:0], ap};
    for (int k = 0; k < NP; k++) begin
      int s;
      int ix [NT];
      logic pv;
      pv = (k == 0) ? 1'b0 : pp[k-1];
      s = 0;
      for (int t = 0; t < NT; t++) begin
        ix[t] = mIdx(t, a, h, k, pv);
        s += mTbl[t][ix[t]];
      end
      if (pp[k] != ap[k] || (s < 0 ? -s : s) <= 3)
        for (int t = 0; t < NT; t++) begin
          if (ap[k] && mTbl[t][ix[t]] < 7) mTbl[t][ix[t]]++;
          else if (!ap[k] && mTbl[t][ix[t]] > -8) mTbl[t][ix[t]]--;
        end
    end
  endtask

  task automatic chk(input string req, input logic [HW-1:0] act, input logic [HW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Drive one block, check timing (R2) and outputs against the model
  task automatic runPredict(input logic [31:0] a, input string req);
    logic [NP-1:0] ep, ec;
    logic [HW-1:0] eh;
    logic early;
    mPredict(a, ep, ec, eh);
    @(negedge clk); predReq = 1'b1; predAddr = a;
    @(negedge clk); predReq = 1'b0;
    early = 1'b0;
    for (int j = 0; j < NP + 1; j++) begin
      if (predValid) early = 1'b1;
      @(negedge clk);
    end
    chk("R2 early valid", HW'(early), HW'(0));
    chk("R2 valid", HW'(predValid), HW'(1));
    chk({req, " path"}, HW'(predPath), HW'(ep));
    chk({req, " conf"}, HW'(predConf), HW'(ec));
    chk("R6 hist", predHist, eh);
    lastPath = predPath; lastConf = predConf; lastHist = predHist;
    @(negedge clk);
    chk("R2 pulse ends", HW'(predValid), HW'(0));
  endtask

  task automatic runUpdate(input logic [31:0] a, input logic [HW-1:0] h,
                           input logic [NP-1:0] pp, input logic [NP-1:0] ap);
    mUpdate(a, h, pp, ap);
    @(negedge clk);
    updValid = 1'b1; updAddr = a; updHist = h; updPredPath = pp; updActualPath = ap;
    @(negedge clk); updValid = 1'b0;
    repeat (NP + 1) @(negedge clk);
  endtask

  localparam logic [35:0] VEC [12] = '{
    {32'h0000_1000, 4'b0000}, {32'h0000_1000, 4'b0000}, {32'h0000_1000, 4'b0000},
    {32'h0000_2044, 4'b1010}, {32'h0000_2044, 4'b1010}, {32'h0000_2044, 4'b0101},
    {32'h0000_1000, 4'b0000}, {32'h0000_3013, 4'b1100}, {32'h0000_3013, 4'b0011},
    {32'h0000_1000, 4'b0000}, {32'h0000_1000, 4'b0110}, {32'h0000_2044, 4'b1010}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual running expected finished");
    summary();
  end

  initial begin
    for (int t = 0; t < NT; t++)
      for (int e = 0; e < 128; e++) mTbl[t][e] = 0;
    mGhr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid low", HW'(predValid), HW'(0));
    chk("R1 hist zero", predHist, '0);
    runPredict(32'h0000_0080, "R1");
    chk("R1 first path ones", HW'(lastPath), HW'(4'b1111));
    chk("R1 first conf zero", HW'(lastConf), HW'(4'b0000));

    // Vector walk: R3 R4 R5 R6 R7 via predict then train
    for (int i = 0; i < 12; i++) begin
      runPredict(VEC[i][35:4], "R3 R4 R5");
      runUpdate(VEC[i][35:4], lastHist, lastPath, VEC[i][3:0]);
    end
    runPredict(32'h0000_1000, "R5 R7 after training");

    // R2: second request while busy is ignored
    begin
      logic [NP-1:0] ep, ec;
      logic [HW-1:0] eh;
      int pulses;
      mPredict(32'h0000_0500, ep, ec, eh);
      @(negedge clk); predReq = 1'b1; predAddr = 32'h0000_0500;
      @(negedge clk); predAddr = 32'h0000_0777;
      @(negedge clk); predReq = 1'b0;
      pulses = 0;
      for (int j = 0; j < 3 * NP; j++) begin
        if (predValid) begin
          pulses++;
          chk("R2 busy path", HW'(predPath), HW'(ep));
        end
        @(negedge clk);
      end
      chk("R2 single pulse", HW'(pulses), HW'(1));
    end

    // R7 saturation and R8 restore
    for (int i = 0; i < 20; i++) runUpdate(32'h0000_0040, '0, 4'b0001, 4'b0000);
    runUpdate(32'h0000_0040, '0, 4'b0000, 4'b1111);
    chk("R8 restore model", mGhr, HW'(4'hF));
    mGhr = HW'(4'h0);
    runUpdate(32'h0000_0040, '0, 4'b0000, 4'b0001);
    runUpdate(32'h0000_0040, '0, 4'b0001, 4'b0000);
    runPredict(32'h0000_0040, "R7");
    chk("R8 restored hist", lastHist, HW'(4'h0));
    chk("R7 saturated predicate 0 value", HW'(lastPath[0]), HW'(0));
    chk("R7 saturated predicate 0 conf", HW'(lastConf[0]), HW'(1));

    // R8: matching paths leave the history alone
    runUpdate(32'h0000_0040, HW'(200'h123), 4'b0110, 4'b0110);
    runPredict(32'h0000_0090, "R8 no restore");

    // R9: updValid while training is ignored
    mUpdate(32'h0000_0090, HW'(200'hABC0), 4'b1111, 4'b0001);
    @(negedge clk);
    updValid = 1'b1; updAddr = 32'h0000_0090; updHist = HW'(200'hABC0);
    updPredPath = 4'b1111; updActualPath = 4'b0001;
    @(negedge clk);
    updAddr = 32'h0000_0091; updHist = HW'(200'h5550);
    updPredPath = 4'b0000; updActualPath = 4'b1110;
    @(negedge clk); updValid = 1'b0;
    repeat (NP + 1) @(negedge clk);
    runPredict(32'h0000_0090, "R9");
    chk("R9 hist from first request", lastHist, {HW'(200'hABC0) << 4} | HW'(4'b0001));

    summary();
  end
endmodule